// File: doc/BRIEF.md
# Timer Interrupt Enable and Status Word

This block keeps the interrupt state for a set of countdown timer channels (five by default) in one register word. The low field holds one enable bit per channel. Software writes it directly. The next field holds one sticky status flag per channel. A channel's expiry pulse sets its flag, and software clears a flag by writing a one to it. Every channel drives its own interrupt line.

A line rises only when its channel expires while that channel's enable bit is set. It stays high until software clears the status flag. Changing the enable bit later neither raises nor lowers a line. The readback value always shows the current register contents, and the bits above the status field read as zero.

Top module: `tmr_irq_ctl`

## Requirements
- R1: Readback bits [4:0] hold the enables, with channel n at bit n. Bits [9:5] hold the status flags, with channel n at bit 5+n.
- R2: A write loads bits [4:0] of the write data into the enables. The new value is visible in the cycle after the write edge.
- R3: On a write, a status flag whose write-data bit (5+n) is 1 clears. A flag whose write-data bit is 0 keeps its value.
- R4: An expiry pulse on channel n sets status flag n, whatever the channel's enable bit is.
- R5: An expiry on channel n raises interrupt line n only if enable n was set before that edge. An enable written in the same cycle as the expiry does not count.
- R6: An interrupt line falls only when its status flag goes from 1 to 0. Clearing the enable leaves a raised line high.
- R7: Setting an enable while its status flag is already set does not raise the line.
- R8: If an expiry and a write-one clear hit the same status flag in the same cycle, the flag stays set. The line is kept, or raised when the channel is enabled.
- R9: Reset clears the enables, the status flags and the interrupt lines.
- R10: Readback bits above bit 9 are always zero, whatever value was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data |
| expire | input | 5 | Per-channel expiry pulses |
| rdata | output | 32 | Register readback value |
| irq | output | 5 | Per-channel interrupt lines |

## Verification
Two kinds of event can land on the same edge: a register write and an expiry pulse for the same channel. The bench provokes this in two ways. In the first, a write-one clear meets an expiry on an enabled channel. In the second, a write that sets an enable coincides with that channel's expiry. The readback and the lines are judged one cycle later. In the clear case the flag must survive and the line must be high. In the enable case the flag must be set but the line must stay low, because the enable held before the edge governs.

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
  parameter int NCH = 5,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] expire,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] irq
);
  localparam int PAD = DW - 2 * NCH;

  logic [NCH-1:0] en_q, sts_q, irq_q;
  logic [NCH-1:0] clr, sts_d, en_d, irq_d;

  assign clr   = wr_en ? wdata[2*NCH-1:NCH] : '0;
  assign sts_d = (sts_q & ~clr) | expire;
  assign en_d  = wr_en ? wdata[NCH-1:0] : en_q;
  assign irq_d = (irq_q | (expire & en_q)) & sts_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sts_q <= '0;
      irq_q <= '0;
    end else begin
      en_q  <= en_d;
      sts_q <= sts_d;
      irq_q <= irq_d;
    end
  end

  assign rdata = {{PAD{1'b0}}, sts_q, en_q};
  assign irq   = irq_q;
endmodule

// File: rtl/tmr_irq_ctl_chk.sv
module tmr_irq_ctl_chk #(
  parameter int NCH = 5,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [DW-1:0]  wdata,
  input logic [NCH-1:0] expire,
  input logic [DW-1:0]  rdata,
  input logic [NCH-1:0] irq
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:2*NCH] == '0); // R10

  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata[NCH-1:0] == $past(wdata[NCH-1:0])); // R2

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> rdata[NCH+i]); // R4

    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wdata[NCH+i] && !expire[i] |=> !rdata[NCH+i]); // R3

    AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(expire[i] && rdata[i])); // R5

    AST_LINE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> rdata[NCH+i]); // R6

    AST_HOLD_ON_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] && irq[i] |=> irq[i]); // R8
  end
endmodule

bind tmr_irq_ctl tmr_irq_ctl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
  .expire(expire), .rdata(rdata), .irq(irq)
);

// File: tb/tmr_irq_ctl_test.sv
module tmr_irq_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [4:0]  expire = '0;
  logic [31:0] rdata;
  logic [4:0]  irq;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_irq_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .expire(expire), .rdata(rdata), .irq(irq)
  );

  // {wr, wdata[9:0], expire, exp_rdata[9:0], exp_irq, req}
  localparam int NV = 14;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 10'h005, 5'b00000, 10'h005, 5'b00000, 4'd2},  // R2 enable ch0, ch2
    {1'b0, 10'h000, 5'b00111, 10'h0E5, 5'b00101, 4'd4},  // R4 R5 flags set regardless
    {1'b1, 10'h000, 5'b00000, 10'h0E0, 5'b00101, 4'd6},  // R6 disabling keeps lines
    {1'b1, 10'h002, 5'b00000, 10'h0E2, 5'b00101, 4'd7},  // R7 late enable no rise
    {1'b1, 10'h022, 5'b00000, 10'h0C2, 5'b00100, 4'd3},  // R3 clear ch0 drops line
    {1'b1, 10'h042, 5'b00000, 10'h082, 5'b00100, 4'd3},  // R3 clear ch1
    {1'b0, 10'h000, 5'b00010, 10'h0C2, 5'b00110, 4'd5},  // R5 enabled expiry
    {1'b1, 10'h042, 5'b00010, 10'h0C2, 5'b00110, 4'd8},  // R8 clear vs expiry
    {1'b1, 10'h010, 5'b10000, 10'h2D0, 5'b00110, 4'd5},  // R5 enable same edge
    {1'b0, 10'h000, 5'b10000, 10'h2D0, 5'b10110, 4'd5},  // R5 now enabled
    {1'b1, 10'h3E0, 5'b00000, 10'h000, 5'b00000, 4'd6},  // R6 clear all
    {1'b1, 10'h01F, 5'b01000, 10'h11F, 5'b00000, 4'd5},  // R5 enable same edge
    {1'b1, 10'h01F, 5'b00000, 10'h11F, 5'b00000, 4'd3},  // R3 zeros leave flags
    {1'b1, 10'h11F, 5'b01000, 10'h11F, 5'b01000, 4'd8}   // R8 race raises line
  };

  task automatic check(input int req, input logic [31:0] er, input logic [4:0] ei);
    checks++;
    if (rdata !== er || irq !== ei) begin
      errors++;
      $display("FAIL R%0d: rdata=%h irq=%b expected rdata=%h irq=%b",
               req, rdata, irq, er, ei);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(9, 32'h0, 5'h0);  // R9 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 32'h0, 5'h0);  // R1 idle after reset

    for (int i = 0; i < NV; i++) begin
      wr_en  = VEC[i][34];
      wdata  = {22'h0, VEC[i][33:24]};
      expire = VEC[i][23:19];
      @(negedge clk);
      wr_en  = 1'b0;
      wdata  = '0;
      expire = '0;
      check(int'(VEC[i][3:0]), {22'h0, VEC[i][18:9]}, VEC[i][8:4]);
    end

    // R10: all ones written, upper bits stay zero; R1 layout, R6 ch3 drops
    wr_en = 1'b1; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    check(10, 32'h0000_001F, 5'h00);

    // R1: single channel expiry lands at bit 5+n, line n
    expire = 5'b10000;
    @(negedge clk);
    expire = '0;
    check(1, 32'h0000_021F, 5'b10000);

    // R9: reset mid-run clears everything
    expire = 5'b11111;
    @(negedge clk);
    expire = '0;
    rst_n = 1'b0;
    @(negedge clk);
    check(9, 32'h0, 5'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(9, 32'h0, 5'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule